// File: doc/BRIEF.md
# DRAM Software Command Injector

This block is a small register bank on a Wishbone slave port. Through it, software can place single commands on the command interface of a DDR3 PHY, or give that interface to a hardware memory controller. It is mainly used for bring-up. Software raises CKE, ODT and the memory reset pin by hand. It then loads a DRAM address, a bank address and a command pattern, and fires each mode-register write or ZQ calibration with a one-shot issue write. When the memory is ready, software sets a select bit, and from then on the controller's command signals pass straight through.

The register bank holds:

- the control bits;
- the command pattern, with the fields active-high;
- the DRAM row/column address (14 bits);
- the bank address (3 bits).

A write of 1 to the issue register produces exactly one clock cycle with the stored pattern, inverted, on the active-low command pins. In every other cycle under software control the pins hold NOP.

The Wishbone side gives a registered acknowledge one cycle after it accepts a request. The master holds `wb_stb_i` until it sees `wb_ack_o`. The slave never stalls longer than that one cycle, and it will not accept a new request in the cycle in which it acknowledges.

Top module: `dfi_cmd_injector`

## Requirements
- R1: After reset the control, command, address and bank registers are all zero. This means CKE=0, ODT=0, the memory reset pin is low (asserted), software has control and the command pins show NOP.
- R2: Each request with `wb_cyc_i` and `wb_stb_i` high gets `wb_ack_o` for exactly one cycle, starting the cycle after acceptance. A read returns the stored register value on `wb_dat_o` in the acknowledge cycle.
- R3: The control register, at word index 0, maps its bits to pins as follows: bit 1 drives `dram_cke_o`, bit 2 drives `dram_odt_o` and bit 3 drives `dram_reset_n_o`. Each pin follows its bit from the cycle after the write.
- R4: While control bit 0 is 0 and no issue is active, the pins show NOP: `dram_cs_n_o`=0 and `dram_ras_n_o`, `dram_cas_n_o` and `dram_we_n_o` all 1.
- R5: The command register is at word index 1, with CS at bit 0, WE at bit 1, CAS at bit 2 and RAS at bit 3. A write with data bit 0 set to the issue register, at word index 2, made while control bit 0 is 0, drives the inverted command bits onto the active-low pins for exactly the one cycle after the write. NOP follows that cycle.
- R6: Under software control, `dram_addr_o` and `dram_bank_o` show the address register (word index 3) and the bank register (word index 4), including during the issue cycle.
- R7: While control bit 0 is 1, the hardware controller's command, address and bank inputs appear unchanged on the DRAM pins, cycle by cycle.
- R8: A write to the issue register while control bit 0 is 1 has no effect. No command appears, then or after software control returns.
- R9: A write to the issue register with data bit 0 equal to 0 produces no command cycle.
- R10: The address register keeps only its low 14 bits and the bank register only its low 3 bits. The issue register and unmapped word indices (5 to 7) read as zero, and writes to the unmapped indices change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Wishbone cycle |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 3 | Word index of the register |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with acknowledge |
| wb_ack_o | output | 1 | Acknowledge |
| hw_cs_n_i | input | 1 | Controller chip select, active low |
| hw_ras_n_i | input | 1 | Controller RAS, active low |
| hw_cas_n_i | input | 1 | Controller CAS, active low |
| hw_we_n_i | input | 1 | Controller write enable, active low |
| hw_addr_i | input | 14 | Controller DRAM address |
| hw_bank_i | input | 3 | Controller bank address |
| dram_cs_n_o | output | 1 | Chip select pin |
| dram_ras_n_o | output | 1 | RAS pin |
| dram_cas_n_o | output | 1 | CAS pin |
| dram_we_n_o | output | 1 | Write enable pin |
| dram_addr_o | output | 14 | DRAM address pins |
| dram_bank_o | output | 3 | Bank address pins |
| dram_cke_o | output | 1 | Clock enable |
| dram_odt_o | output | 1 | On-die termination |
| dram_reset_n_o | output | 1 | Memory reset, active low |

## Verification
The bench issues two command patterns. The mode-register pattern (all four fields set) drives every pin low. The ZQ pattern (CS and WE only) separates the RAS and CAS lanes from the WE and CS lanes, so a swapped or uninverted bit shows up. An issue write with bit 0 clear, and one made under hardware control, must both leave NOP. This tells a decoder that looks at the data bit and the select state apart from one that fires on any access. Passthrough is tested with hardware inputs that change while selected, which separates a live path from a latched copy. Write/readback of out-of-range values checks the masking of the address and bank registers.

// File: rtl/dfi_inj_pkg.sv
package dfi_inj_pkg;

  localparam int DATA_W = 32;

  // byte offsets of the register windows
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CMD   = 'h04;
  localparam int OFS_ISSUE = 'h08;
  localparam int OFS_ADDR  = 'h0C;
  localparam int OFS_BANK  = 'h10;

  // control field positions
  localparam int CTRL_SEL  = 0;
  localparam int CTRL_CKE  = 1;
  localparam int CTRL_ODT  = 2;
  localparam int CTRL_RSTN = 3;
  localparam int CTRL_W    = 4;

  // command pattern, active high; cs is bit 0
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic cs;
  } cmd_t;

  // pin view of a command, active low
  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cs_n;
  } pins_t;

  localparam pins_t PINS_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cs_n: 1'b0};

endpackage

// File: rtl/inj_regfile.sv
module inj_regfile
  import dfi_inj_pkg::*;
#(
  parameter int WB_AW  = 3,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [WB_AW-1:0]  wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output cmd_t              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              issue_req_o
);

  localparam logic [WB_AW-1:0] IX_CTRL  = WB_AW'(OFS_CTRL  >> 2);
  localparam logic [WB_AW-1:0] IX_CMD   = WB_AW'(OFS_CMD   >> 2);
  localparam logic [WB_AW-1:0] IX_ISSUE = WB_AW'(OFS_ISSUE >> 2);
  localparam logic [WB_AW-1:0] IX_ADDR  = WB_AW'(OFS_ADDR  >> 2);
  localparam logic [WB_AW-1:0] IX_BANK  = WB_AW'(OFS_BANK  >> 2);

  logic              ack_q;
  logic [DATA_W-1:0] rdat_q;
  logic [CTRL_W-1:0] ctrl_q;
  cmd_t              cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic              req, wr, rd;
  logic [DATA_W-1:0] rdata;

  // a new request is taken only when no ack is pending
  assign req = wb_cyc_i && wb_stb_i && !ack_q;
  assign wr  = req && wb_we_i;
  assign rd  = req && !wb_we_i;

  always_comb begin
    rdata = '0;
    case (wb_adr_i)
      IX_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
      IX_CMD:  rdata[3:0]        = cmd_q;
      IX_ADDR: rdata[ADDR_W-1:0] = addr_q;
      IX_BANK: rdata[BANK_W-1:0] = bank_q;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
      ctrl_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      bank_q <= '0;
    end else begin
      ack_q <= req;
      if (rd) rdat_q <= rdata;
      if (wr) begin
        case (wb_adr_i)
          IX_CTRL: ctrl_q <= wb_dat_i[CTRL_W-1:0];
          IX_CMD:  cmd_q  <= cmd_t'(wb_dat_i[3:0]);
          IX_ADDR: addr_q <= wb_dat_i[ADDR_W-1:0];
          IX_BANK: bank_q <= wb_dat_i[BANK_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic unused_hi;
  assign unused_hi = ^wb_dat_i[DATA_W-1:ADDR_W];

  assign wb_ack_o    = ack_q;
  assign wb_dat_o    = rdat_q;
  assign ctrl_o      = ctrl_q;
  assign cmd_o       = cmd_q;
  assign addr_o      = addr_q;
  assign bank_o      = bank_q;
  assign issue_req_o = wr && (wb_adr_i == IX_ISSUE) && wb_dat_i[0];

endmodule

// File: rtl/inj_issue.sv
module inj_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_req_i,
  input  logic hw_sel_i,
  output logic pulse_o
);

  logic pulse_q;

  // the select state at acceptance decides whether the shot fires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= issue_req_i && !hw_sel_i;
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/inj_pin_mux.sv
module inj_pin_mux
  import dfi_inj_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              hw_sel_i,
  input  logic              pulse_i,
  input  cmd_t              sw_cmd_i,
  input  logic [ADDR_W-1:0] sw_addr_i,
  input  logic [BANK_W-1:0] sw_bank_i,
  input  pins_t             hw_pins_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic [BANK_W-1:0] hw_bank_i,
  output pins_t             pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o
);

  always_comb begin
    if (hw_sel_i) begin
      pins_o = hw_pins_i;
      addr_o = hw_addr_i;
      bank_o = hw_bank_i;
    end else begin
      addr_o = sw_addr_i;
      bank_o = sw_bank_i;
      pins_o = pulse_i ? pins_t'(~sw_cmd_i) : PINS_NOP;
    end
  end

endmodule

// File: rtl/dfi_cmd_injector.sv
module dfi_cmd_injector
  import dfi_inj_pkg::*;
#(
  parameter int WB_AW  = 3,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [WB_AW-1:0]  wb_adr_i,
  input  logic [31:0]       wb_dat_i,
  output logic [31:0]       wb_dat_o,
  output logic              wb_ack_o,
  input  logic              hw_cs_n_i,
  input  logic              hw_ras_n_i,
  input  logic              hw_cas_n_i,
  input  logic              hw_we_n_i,
  input  logic [ADDR_W-1:0] hw_addr_i,
  input  logic [BANK_W-1:0] hw_bank_i,
  output logic              dram_cs_n_o,
  output logic              dram_ras_n_o,
  output logic              dram_cas_n_o,
  output logic              dram_we_n_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic [BANK_W-1:0] dram_bank_o,
  output logic              dram_cke_o,
  output logic              dram_odt_o,
  output logic              dram_reset_n_o
);

  logic [CTRL_W-1:0] ctrl;
  cmd_t              sw_cmd;
  logic [ADDR_W-1:0] sw_addr;
  logic [BANK_W-1:0] sw_bank;
  logic              issue_req;
  logic              issue_pulse;
  logic              sw_sel;
  pins_t             hw_pins;
  pins_t             pins;

  inj_regfile #(.WB_AW(WB_AW), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wb_cyc_i    (wb_cyc_i),
    .wb_stb_i    (wb_stb_i),
    .wb_we_i     (wb_we_i),
    .wb_adr_i    (wb_adr_i),
    .wb_dat_i    (wb_dat_i),
    .wb_dat_o    (wb_dat_o),
    .wb_ack_o    (wb_ack_o),
    .ctrl_o      (ctrl),
    .cmd_o       (sw_cmd),
    .addr_o      (sw_addr),
    .bank_o      (sw_bank),
    .issue_req_o (issue_req)
  );

  assign sw_sel = ctrl[CTRL_SEL];

  inj_issue u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_req_i (issue_req),
    .hw_sel_i    (sw_sel),
    .pulse_o     (issue_pulse)
  );

  assign hw_pins = '{ras_n: hw_ras_n_i, cas_n: hw_cas_n_i, we_n: hw_we_n_i, cs_n: hw_cs_n_i};

  inj_pin_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
    .hw_sel_i  (sw_sel),
    .pulse_i   (issue_pulse),
    .sw_cmd_i  (sw_cmd),
    .sw_addr_i (sw_addr),
    .sw_bank_i (sw_bank),
    .hw_pins_i (hw_pins),
    .hw_addr_i (hw_addr_i),
    .hw_bank_i (hw_bank_i),
    .pins_o    (pins),
    .addr_o    (dram_addr_o),
    .bank_o    (dram_bank_o)
  );

  assign dram_cs_n_o    = pins.cs_n;
  assign dram_ras_n_o   = pins.ras_n;
  assign dram_cas_n_o   = pins.cas_n;
  assign dram_we_n_o    = pins.we_n;
  assign dram_cke_o     = ctrl[CTRL_CKE];
  assign dram_odt_o     = ctrl[CTRL_ODT];
  assign dram_reset_n_o = ctrl[CTRL_RSTN];

endmodule

// File: rtl/inj_checker.sv
module inj_checker #(
  parameter int WB_AW  = 3,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wb_cyc_i,
  input logic              wb_stb_i,
  input logic              wb_we_i,
  input logic [WB_AW-1:0]  wb_adr_i,
  input logic [31:0]       wb_dat_i,
  input logic              wb_ack_o,
  input logic              sw_sel,
  input logic              issue_pulse,
  input logic              hw_ras_n_i,
  input logic [ADDR_W-1:0] hw_addr_i,
  input logic [BANK_W-1:0] hw_bank_i,
  input logic              dram_cs_n_o,
  input logic              dram_ras_n_o,
  input logic              dram_cas_n_o,
  input logic              dram_we_n_o,
  input logic [ADDR_W-1:0] dram_addr_o,
  input logic [BANK_W-1:0] dram_bank_o
);

  a_r2_ack_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);

  a_r2_ack_has_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

  a_r4_idle_is_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_sel && !issue_pulse) |-> (!dram_cs_n_o && dram_ras_n_o && dram_cas_n_o && dram_we_n_o));

  a_r5_single_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_pulse |=> !issue_pulse);

  a_r5_shot_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_pulse |-> $past(wb_cyc_i && wb_stb_i && wb_we_i && wb_adr_i == WB_AW'(2) && wb_dat_i[0]));

  a_r8_no_shot_under_hw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_pulse |-> !sw_sel);

  a_r7_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sel |-> (dram_ras_n_o == hw_ras_n_i && dram_addr_o == hw_addr_i && dram_bank_o == hw_bank_i));

endmodule

bind dfi_cmd_injector inj_checker #(.WB_AW(WB_AW), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wb_cyc_i     (wb_cyc_i),
  .wb_stb_i     (wb_stb_i),
  .wb_we_i      (wb_we_i),
  .wb_adr_i     (wb_adr_i),
  .wb_dat_i     (wb_dat_i),
  .wb_ack_o     (wb_ack_o),
  .sw_sel       (sw_sel),
  .issue_pulse  (issue_pulse),
  .hw_ras_n_i   (hw_ras_n_i),
  .hw_addr_i    (hw_addr_i),
  .hw_bank_i    (hw_bank_i),
  .dram_cs_n_o  (dram_cs_n_o),
  .dram_ras_n_o (dram_ras_n_o),
  .dram_cas_n_o (dram_cas_n_o),
  .dram_we_n_o  (dram_we_n_o),
  .dram_addr_o  (dram_addr_o),
  .dram_bank_o  (dram_bank_o)
);

// File: tb/dfi_cmd_injector_tb.sv
`timescale 1ns/1ps
module dfi_cmd_injector_tb;

  localparam logic [2:0] I_CTRL = 3'd0, I_CMD = 3'd1, I_ISS = 3'd2, I_ADDR = 3'd3, I_BANK = 3'd4;
  localparam logic [3:0] NOP = 4'b1110;  // {ras_n,cas_n,we_n,cs_n}

  typedef struct packed {
    logic [2:0]  adr;
    logic [31:0] wdat;
    logic [31:0] rexp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{I_CMD,  32'h0000_000F, 32'h0000_000F},
    '{I_CMD,  32'hFFFF_FFF3, 32'h0000_0003},
    '{I_ADDR, 32'h0000_0400, 32'h0000_0400},
    '{I_ADDR, 32'hFFFF_FFFF, 32'h0000_3FFF},
    '{I_BANK, 32'h0000_0002, 32'h0000_0002},
    '{I_BANK, 32'hFFFF_FFFD, 32'h0000_0005},
    '{I_ISS,  32'h0000_0000, 32'h0000_0000},
    '{3'd5,   32'h0000_1234, 32'h0000_0000},
    '{I_CTRL, 32'h0000_000C, 32'h0000_000C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [2:0] adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic ack;
  logic hcs = 1'b0, hras = 1'b1, hcas = 1'b1, hwe = 1'b1;
  logic [13:0] haddr = '0;
  logic [2:0] hbank = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, odt, mrst_n;
  logic [13:0] daddr;
  logic [2:0] dbank;

  int checks = 0;
  int errors = 0;
  logic [3:0]  snap_pins;
  logic [13:0] snap_addr;
  logic [2:0]  snap_bank;
  logic [31:0] rd_val;

  always #4 clk = ~clk;

  dfi_cmd_injector u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we), .wb_adr_i(adr),
    .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .hw_cs_n_i(hcs), .hw_ras_n_i(hras), .hw_cas_n_i(hcas), .hw_we_n_i(hwe),
    .hw_addr_i(haddr), .hw_bank_i(hbank),
    .dram_cs_n_o(cs_n), .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
    .dram_addr_o(daddr), .dram_bank_o(dbank),
    .dram_cke_o(cke), .dram_odt_o(odt), .dram_reset_n_o(mrst_n)
  );

  function automatic logic [3:0] pins();
    return {ras_n, cas_n, we_n, cs_n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives at posedge+1; snapshots the acknowledge cycle
  task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
    cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = a; wdat = d;
    @(posedge clk); #1;
    chk("R2 write ack", {31'd0, ack}, 32'd1);
    snap_pins = pins(); snap_addr = daddr; snap_bank = dbank;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [31:0] d);
    cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = a;
    @(posedge clk); #1;
    chk("R2 read ack", {31'd0, ack}, 32'd1);
    d = rdat;
    cyc = 1'b0; stb = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 pins NOP", {28'd0, pins()}, {28'd0, NOP});
    chk("R1 static pins", {29'd0, cke, odt, mrst_n}, 32'd0);
    chk("R1 addr/bank", {15'd0, daddr, dbank}, 32'd0);
    chk("R1 no ack", {31'd0, ack}, 32'd0);
    wb_read(I_CTRL, rd_val);
    chk("R1 ctrl zero", rd_val, 32'd0);

    // table: write then read back (R2, R10)
    for (int i = 0; i < NV; i++) begin
      wb_write(VECS[i].adr, VECS[i].wdat);
      chk("R9 table shot-free", {28'd0, snap_pins}, {28'd0, NOP});
      wb_read(VECS[i].adr, rd_val);
      chk("R10 readback", rd_val, VECS[i].rexp);
    end

    // R3: 0x0C -> odt, reset_n high, cke low
    chk("R3 ctrl 0x0C", {29'd0, cke, odt, mrst_n}, 32'b011);
    wb_write(I_CTRL, 32'h0E);
    chk("R3 ctrl 0x0E", {29'd0, cke, odt, mrst_n}, 32'b111);
    chk("R4 idle NOP", {28'd0, pins()}, {28'd0, NOP});

    // R5/R6 mode-register pattern
    wb_write(I_ADDR, 32'h200);
    wb_write(I_BANK, 32'h2);
    chk("R6 addr idle", {18'd0, daddr}, 32'h200);
    wb_write(I_CMD, 32'hF);
    chk("R4 NOP after cmd load", {28'd0, pins()}, {28'd0, NOP});
    wb_write(I_ISS, 32'h1);
    chk("R5 MRS pins", {28'd0, snap_pins}, 32'b0000);
    chk("R6 MRS addr", {18'd0, snap_addr}, 32'h200);
    chk("R6 MRS bank", {29'd0, snap_bank}, 32'h2);
    chk("R5 NOP after shot", {28'd0, pins()}, {28'd0, NOP});

    // R5 ZQ pattern: only cs and we
    wb_write(I_ADDR, 32'h400);
    wb_write(I_BANK, 32'h0);
    wb_write(I_CMD, 32'h3);
    wb_write(I_ISS, 32'h1);
    chk("R5 ZQ pins", {28'd0, snap_pins}, 32'b1100);
    chk("R6 ZQ addr", {18'd0, snap_addr}, 32'h400);
    chk("R5 NOP after ZQ", {28'd0, pins()}, {28'd0, NOP});

    // R9 issue with bit0 clear
    wb_write(I_ISS, 32'hFE);
    chk("R9 no shot", {28'd0, snap_pins}, {28'd0, NOP});

    // R7 hardware passthrough
    hcs = 1'b0; hras = 1'b0; hcas = 1'b1; hwe = 1'b0; haddr = 14'h1ABC; hbank = 3'd5;
    wb_write(I_CTRL, 32'h0F);
    chk("R7 pins", {28'd0, pins()}, 32'b0100);
    chk("R7 addr", {18'd0, daddr}, 32'h1ABC);
    chk("R7 bank", {29'd0, dbank}, 32'd5);
    chk("R3 static under hw", {29'd0, cke, odt, mrst_n}, 32'b111);
    hcs = 1'b1; hras = 1'b1; hcas = 1'b0; hwe = 1'b1; haddr = 14'h0123; hbank = 3'd6;
    #1;
    chk("R7 live pins", {28'd0, pins()}, 32'b1011);
    chk("R7 live addr", {18'd0, daddr}, 32'h0123);

    // R8 issue under hw select
    wb_write(I_ISS, 32'h1);
    chk("R8 hw pins kept", {28'd0, snap_pins}, 32'b1011);
    wb_write(I_CTRL, 32'h0E);
    chk("R8 no late shot", {28'd0, snap_pins}, {28'd0, NOP});
    chk("R8 NOP after return", {28'd0, pins()}, {28'd0, NOP});
    chk("R6 sw addr back", {18'd0, daddr}, 32'h400);

    // R3 hardware-select only
    wb_write(I_CTRL, 32'h01);
    chk("R3 ctrl 0x01", {29'd0, cke, odt, mrst_n}, 32'b000);

    summary();
  end

endmodule